// File: doc/BRIEF.md
# Interrupt Status Collector with Clear-on-Read

This block gathers single-cycle event pulses from a two-wire serial bus controller into sticky status bits. It adds two level indications that follow the receive and transmit FIFO thresholds, and it gates the result through a mask register onto one interrupt line. Software reads the status through a small registered read port. A read of a status word has no side effects. A read of a clear address both reports and clears a bit.

Each sticky source has its own clear-on-read address. This lets a handler clear exactly the bits it has just seen, so an event that arrives between the status read and the clear is not lost. A combined clear address clears every sticky bit in one read. When a transmit abort occurs, a cause code is captured with it. That code is cleared by the same read that clears the abort bit. While the controller enable input is low, all sticky bits and the cause code are held at zero.

Top module: `irq_status_unit`

## Requirements
- R1: Source bit positions are: 0 start seen, 1 stop seen, 2 bus activity, 3 read finished, 4 transmit abort, 5 read request, 6 receive underflow, 7 receive overflow, 8 transmit overflow, 9 general call, 10 receive level, 11 transmit level. A pulse on `evtPulse[i]` for a sticky bit (0 to 9) sets raw bit i. Raw status reads at address 0, and the new bit is visible from the clock edge after the pulse.
- R2: Address 1 reads raw status ANDed with the mask. The mask is written through `maskWr`/`maskWdata` and reads at address 2. `irqOut` is high exactly when some masked bit is set.
- R3: A read of address 8+i (i from 0 to 9) clears only sticky bit i. It returns 1 in bit 0 if that bit was set, and 0 otherwise.
- R4: A read of address 4 clears all sticky bits at once. It returns 1 in bit 0 if any sticky bit was set.
- R5: An event that arrives in the same cycle as a clear read of its bit leaves that bit set.
- R6: An abort pulse loads `abortCode` into a cause register that reads at address 3. Any clear read that clears bit 4 also zeroes the cause register.
- R7: Bits 10 and 11 follow `rxAtThresh` and `txAtThresh` one cycle later. No clear read changes them, and their clear addresses (18, 19) return 0.
- R8: While `ctrlEnable` is low, all sticky bits and the cause register are held at zero and event pulses are ignored.
- R9: After reset, status, mask, cause register, `rdData` and `irqOut` are zero. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlEnable | input | 1 | Controller enable; low holds sticky bits cleared |
| evtPulse | input | 12 | Event pulses, one per source bit |
| rxAtThresh | input | 1 | Receive FIFO at or above its threshold |
| txAtThresh | input | 1 | Transmit FIFO at or below its threshold |
| abortCode | input | 8 | Abort cause, sampled with the abort pulse |
| maskWr | input | 1 | Mask register write strobe |
| maskWdata | input | 12 | Mask write value |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 5 | Read address |
| rdData | output | 16 | Read data, registered |
| irqOut | output | 1 | Interrupt line |

## Verification
Every result is due one clock edge after its stimulus. A read issued in cycle k shows its data on `rdData` after edge k+1, and that data reflects the state before any clear the read performs. Events, threshold changes and mask writes reach raw status and `irqOut` at the same edge. The bench drives inputs on the falling edge and samples on the next falling edge, so each check falls half a cycle after the edge that produced its result. Clear effects are checked by a second read one cycle later.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int NUM_SRC = 12;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 16;
  localparam int CODE_W  = 8;

  localparam int IDX_ABORT = 4;
  localparam int IDX_RXLVL = 10;
  localparam int IDX_TXLVL = 11;
  localparam logic [NUM_SRC-1:0] LEVEL_MASK  =
    (NUM_SRC'(1) << IDX_RXLVL) | (NUM_SRC'(1) << IDX_TXLVL);
  localparam logic [NUM_SRC-1:0] STICKY_MASK = ~LEVEL_MASK;

  localparam logic [ADDR_W-1:0] A_RAW      = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MASKED   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MASK     = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CODE     = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CLRALL   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CLRBASE  = ADDR_W'(8);

  typedef enum logic [2:0] {
    SEL_NONE, SEL_RAW, SEL_MASKED, SEL_MASK, SEL_CODE, SEL_CLRALL, SEL_CLRONE
  } rdSel_e;

  typedef struct packed {
    logic [NUM_SRC-1:0] clrVec;
    logic               clrAll;
    rdSel_e             sel;
  } strobe_t;
endpackage

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
(
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output strobe_t           strb
);
  logic [ADDR_W-1:0] clrIdx;
  logic              inClrRange;

  assign clrIdx     = rdAddr - A_CLRBASE;
  assign inClrRange = (rdAddr >= A_CLRBASE) &&
                      ({1'b0, rdAddr} < ({1'b0, A_CLRBASE} + (ADDR_W+1)'(NUM_SRC)));

  always_comb begin
    strb = '{clrVec: '0, clrAll: 1'b0, sel: SEL_NONE};
    if (rdEn) begin
      unique case (rdAddr)
        A_RAW:    strb.sel = SEL_RAW;
        A_MASKED: strb.sel = SEL_MASKED;
        A_MASK:   strb.sel = SEL_MASK;
        A_CODE:   strb.sel = SEL_CODE;
        A_CLRALL: begin
          strb.sel    = SEL_CLRALL;
          strb.clrAll = 1'b1;
        end
        default: begin
          if (inClrRange) begin
            strb.sel    = SEL_CLRONE;
            strb.clrVec = (NUM_SRC'(1) << clrIdx) & STICKY_MASK;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/irq_status_datapath.sv
module irq_status_datapath
  import irq_status_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlEnable,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic               rxAtThresh,
  input  logic               txAtThresh,
  input  logic [CODE_W-1:0]  abortCode,
  input  logic               maskWr,
  input  logic [NUM_SRC-1:0] maskWdata,
  input  strobe_t            strb,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_SRC-1:0] rawStatus,
  output logic [NUM_SRC-1:0] maskReg,
  output logic [CODE_W-1:0]  abortReg,
  output logic               irqOut
);
  logic [NUM_SRC-1:0] stickyReg, levelReg, clrNow, stickyNext, evtSticky;
  logic [NUM_SRC-1:0] levelNext;
  logic [DATA_W-1:0]  rdNext;

  assign evtSticky = evtPulse & STICKY_MASK;
  assign clrNow    = strb.clrAll ? STICKY_MASK : strb.clrVec;
  assign stickyNext = ctrlEnable ? ((stickyReg & ~clrNow) | evtSticky) : '0;

  always_comb begin
    levelNext = '0;
    levelNext[IDX_RXLVL] = rxAtThresh;
    levelNext[IDX_TXLVL] = txAtThresh;
  end

  assign rawStatus = stickyReg | levelReg;
  assign irqOut    = |(rawStatus & maskReg);

  always_comb begin
    unique case (strb.sel)
      SEL_RAW:    rdNext = DATA_W'(rawStatus);
      SEL_MASKED: rdNext = DATA_W'(rawStatus & maskReg);
      SEL_MASK:   rdNext = DATA_W'(maskReg);
      SEL_CODE:   rdNext = DATA_W'(abortReg);
      SEL_CLRALL: rdNext = DATA_W'(|stickyReg);
      SEL_CLRONE: rdNext = DATA_W'(|(stickyReg & strb.clrVec));
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stickyReg <= '0;
      levelReg  <= '0;
      maskReg   <= '0;
      abortReg  <= '0;
      rdData    <= '0;
    end else begin
      stickyReg <= stickyNext;
      levelReg  <= levelNext;
      rdData    <= rdNext;
      if (maskWr) maskReg <= maskWdata;
      if (!ctrlEnable)             abortReg <= '0;
      else if (evtPulse[IDX_ABORT]) abortReg <= abortCode;
      else if (clrNow[IDX_ABORT])   abortReg <= '0;
    end
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlEnable,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic               rxAtThresh,
  input  logic               txAtThresh,
  input  logic [CODE_W-1:0]  abortCode,
  input  logic               maskWr,
  input  logic [NUM_SRC-1:0] maskWdata,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);
  strobe_t            strb;
  logic [NUM_SRC-1:0] rawStatus, maskReg;
  logic [CODE_W-1:0]  abortReg;

  irq_status_ctrl u_ctrl (
    .rdEn   (rdEn),
    .rdAddr (rdAddr),
    .strb   (strb)
  );

  irq_status_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlEnable (ctrlEnable),
    .evtPulse   (evtPulse),
    .rxAtThresh (rxAtThresh),
    .txAtThresh (txAtThresh),
    .abortCode  (abortCode),
    .maskWr     (maskWr),
    .maskWdata  (maskWdata),
    .strb       (strb),
    .rdData     (rdData),
    .rawStatus  (rawStatus),
    .maskReg    (maskReg),
    .abortReg   (abortReg),
    .irqOut     (irqOut)
  );
endmodule

// File: rtl/irq_status_checks.sv
module irq_status_checks
  import irq_status_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               ctrlEnable,
  input logic [NUM_SRC-1:0] evtPulse,
  input logic               rxAtThresh,
  input logic               rdEn,
  input logic [ADDR_W-1:0]  rdAddr,
  input logic [NUM_SRC-1:0] rawStatus,
  input logic [NUM_SRC-1:0] maskReg,
  input logic [CODE_W-1:0]  abortReg,
  input logic               irqOut
);
  assert_event_sets_R1: assert property (@(posedge clk) disable iff (!rstN)
    ctrlEnable |=> ((rawStatus & $past(evtPulse & STICKY_MASK)) == $past(evtPulse & STICKY_MASK)));

  assert_irq_needs_mask_R2: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (maskReg != '0));

  assert_abort_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == (A_CLRBASE + ADDR_W'(IDX_ABORT)) && !evtPulse[IDX_ABORT])
      |=> (!rawStatus[IDX_ABORT] && abortReg == '0));

  assert_clear_all_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == A_CLRALL && evtPulse == '0) |=> ((rawStatus & STICKY_MASK) == '0));

  assert_level_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (rawStatus[IDX_RXLVL] == $past(rxAtThresh)));

  assert_disable_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEnable |=> ((rawStatus & STICKY_MASK) == '0 && abortReg == '0));
endmodule

bind irq_status_unit irq_status_checks u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ctrlEnable (ctrlEnable),
  .evtPulse   (evtPulse),
  .rxAtThresh (rxAtThresh),
  .rdEn       (rdEn),
  .rdAddr     (rdAddr),
  .rawStatus  (rawStatus),
  .maskReg    (maskReg),
  .abortReg   (abortReg),
  .irqOut     (irqOut)
);

// File: tb/irq_status_unit_bench.sv
module irq_status_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlEnable = 1'b0;
  logic [11:0] evtPulse = '0;
  logic        rxAtThresh = 1'b0;
  logic        txAtThresh = 1'b0;
  logic [7:0]  abortCode = '0;
  logic        maskWr = 1'b0;
  logic [11:0] maskWdata = '0;
  logic        rdEn = 1'b0;
  logic [4:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_status_unit u_irq_status_unit (
    .clk(clk), .rstN(rstN), .ctrlEnable(ctrlEnable), .evtPulse(evtPulse),
    .rxAtThresh(rxAtThresh), .txAtThresh(txAtThresh), .abortCode(abortCode),
    .maskWr(maskWr), .maskWdata(maskWdata), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .irqOut(irqOut)
  );

  typedef struct packed {
    logic [11:0] evt;
    logic        rx;
    logic        mwr;
    logic [11:0] mdata;
    logic        rd;
    logic [4:0]  addr;
    logic [7:0]  code;
    logic [15:0] expData;
    logic        expIrq;
  } step_t;

  localparam int NSTEP = 17;
  localparam step_t STEPS [NSTEP] = '{
    '{12'h000, 1'b0, 1'b1, 12'h010, 1'b0, 5'd0,  8'h00, 16'h0000, 1'b0}, // set mask R2
    '{12'h002, 1'b0, 1'b0, 12'h000, 1'b1, 5'd0,  8'h00, 16'h0000, 1'b0}, // stop event R1
    '{12'h000, 1'b0, 1'b0, 12'h000, 1'b1, 5'd0,  8'h00, 16'h0002, 1'b0}, // raw R1
    '{12'h010, 1'b0, 1'b0, 12'h000, 1'b1, 5'd1,  8'h5A, 16'h0000, 1'b1}, // abort R2
    '{12'h000, 1'b0, 1'b0, 12'h000, 1'b1, 5'd3,  8'h00, 16'h005A, 1'b1}, // code R6
    '{12'h000, 1'b0, 1'b0, 12'h000, 1'b1, 5'd12, 8'h00, 16'h0001, 1'b0}, // clr abort R3
    '{12'h000, 1'b0, 1'b0, 12'h000, 1'b1, 5'd3,  8'h00, 16'h0000, 1'b0}, // code gone R6
    '{12'h000, 1'b0, 1'b0, 12'h000, 1'b1, 5'd12, 8'h00, 16'h0000, 1'b0}, // clr unset R3
    '{12'h002, 1'b0, 1'b0, 12'h000, 1'b1, 5'd9,  8'h00, 16'h0001, 1'b0}, // event wins R5
    '{12'h000, 1'b0, 1'b0, 12'h000, 1'b1, 5'd0,  8'h00, 16'h0002, 1'b0}, // still set R5
    '{12'h000, 1'b1, 1'b1, 12'h400, 1'b1, 5'd2,  8'h00, 16'h0010, 1'b1}, // rx level R7
    '{12'h000, 1'b1, 1'b0, 12'h000, 1'b1, 5'd18, 8'h00, 16'h0000, 1'b1}, // level clr R7
    '{12'h000, 1'b0, 1'b0, 12'h000, 1'b1, 5'd0,  8'h00, 16'h0402, 1'b0}, // level drop R7
    '{12'h3C0, 1'b0, 1'b0, 12'h000, 1'b1, 5'd4,  8'h00, 16'h0001, 1'b0}, // clr all R4 R5
    '{12'h000, 1'b0, 1'b0, 12'h000, 1'b1, 5'd0,  8'h00, 16'h03C0, 1'b0}, // survivors R5
    '{12'h000, 1'b0, 1'b0, 12'h000, 1'b1, 5'd4,  8'h00, 16'h0001, 1'b0}, // clr all R4
    '{12'h000, 1'b0, 1'b0, 12'h000, 1'b1, 5'd0,  8'h00, 16'h0000, 1'b0}  // empty R4
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [11:0] evt, input logic rd, input logic [4:0] addr);
    evtPulse = evt; rdEn = rd; rdAddr = addr;
    @(negedge clk);
    evtPulse = '0; rdEn = 1'b0; maskWr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 rdData", rdData, 16'h0);
    check("R9 irqOut", 16'(irqOut), 16'h0);
    cyc(12'h0, 1'b1, 5'd0);  check("R9 raw", rdData, 16'h0);
    cyc(12'h0, 1'b1, 5'd2);  check("R9 mask", rdData, 16'h0);
    ctrlEnable = 1'b1;

    for (int i = 0; i < NSTEP; i++) begin
      rxAtThresh = STEPS[i].rx;
      maskWr     = STEPS[i].mwr;
      maskWdata  = STEPS[i].mdata;
      abortCode  = STEPS[i].code;
      cyc(STEPS[i].evt, STEPS[i].rd, STEPS[i].addr);
      check($sformatf("table step %0d data", i), rdData, STEPS[i].expData);
      check($sformatf("table step %0d irq", i), 16'(irqOut), 16'(STEPS[i].expIrq));
    end

    // R8: disable clears sticky state and blocks events
    abortCode = 8'h33;
    cyc(12'h011, 1'b0, 5'd0);
    ctrlEnable = 1'b0;
    cyc(12'h020, 1'b1, 5'd0);
    check("R8 pre-disable raw", rdData, 16'h0011);
    ctrlEnable = 1'b1;
    cyc(12'h0, 1'b1, 5'd0);
    check("R8 cleared raw", rdData, 16'h0000);
    cyc(12'h0, 1'b1, 5'd3);
    check("R8 cleared code", rdData, 16'h0000);

    // R9: unmapped address
    cyc(12'h001, 1'b0, 5'd0);
    cyc(12'h0, 1'b1, 5'd30);
    check("R9 unmapped", rdData, 16'h0000);
    cyc(12'h0, 1'b1, 5'd0);
    check("R3 read at 30 no clear", rdData, 16'h0001);

    // R3: per-source clear touches only its bit
    cyc(12'h200, 1'b0, 5'd0);
    cyc(12'h0, 1'b1, 5'd17);
    check("R3 clr gencall", rdData, 16'h0001);
    cyc(12'h0, 1'b1, 5'd0);
    check("R3 other kept", rdData, 16'h0001);

    // R6: combined clear also drops cause code
    abortCode = 8'hC3;
    cyc(12'h010, 1'b0, 5'd0);
    cyc(12'h0, 1'b1, 5'd3);
    check("R6 code captured", rdData, 16'h00C3);
    cyc(12'h0, 1'b1, 5'd4);
    cyc(12'h0, 1'b1, 5'd3);
    check("R6 code after clear all", rdData, 16'h0000);

    // R7: transmit level bit
    txAtThresh = 1'b1;
    cyc(12'h0, 1'b0, 5'd0);
    cyc(12'h0, 1'b1, 5'd19);
    check("R7 tx clr returns 0", rdData, 16'h0000);
    cyc(12'h0, 1'b1, 5'd0);
    check("R7 tx level", rdData, 16'h0800);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule